// File: doc/BRIEF.md
# Stream-Detecting Cache Prefetcher

This block sits beside a cache and watches the demand accesses it sees. Each access carries a byte address and a context number. The block reduces the address to a cache-block number and trains a small per-context table of stream candidates. An entry learns a direction once two nearby accesses agree about it. After that, the entry keeps a window of block numbers. When an access falls strictly inside that window, the block sends out a burst of block addresses just beyond the window's leading edge and slides the window forward.

The access port has a valid/ready handshake. Prefetch addresses leave through a valid/ready port, one per cycle. An accepted access updates the table in the cycle it is taken. While a burst is being drained, the access port reports not-ready. Context 0 stands for requests with no owner and is accepted but otherwise ignored. When no entry claims an access, the block opens a new candidate in the first free slot. If no slot is free, it reuses the least recently used slot.

Top module: `stream_prefetch`

## Requirements
- R1: The low log2(BLK_BYTES) bits of an access address have no effect on behaviour, and every emitted prefetch address has those bits at zero.
- R2: An access with context 0 is accepted but never trains, allocates or causes a prefetch.
- R3: A training entry takes an access only when the access block is within DISTANCE/2 blocks of the entry's allocation block, in either direction. The vote is "up" if the access is above the allocation block and "down" otherwise. When a second vote agrees with the first, the entry starts monitoring with window start = allocation block and window end = access block ± DEGREE. An access further away leaves the entry untouched.
- R4: When the second vote disagrees with the first, the entry becomes free again.
- R5: A monitoring entry is hit when the access block is strictly between start and end (start < b < end going up, start > b > end going down). A hit emits DEGREE addresses end±1, end±2, … in that order, one per accepted output cycle, starting in the cycle after the access is accepted.
- R6: On a hit, end moves DEGREE blocks in the stream direction. If the new |end − start| exceeds DISTANCE blocks, start moves by the same amount; otherwise start stays where it is.
- R7: An access that matches no entry allocates the lowest-numbered free entry. If there is none, it allocates the entry with recency rank ENTRIES−1. The touched or allocated entry gets rank 0, and every entry that ranked below its old rank moves back by one.
- R8: Each context has its own table, so a stream trained under one context is never hit by another context.
- R9: While a prefetch address is valid and not taken, it holds steady. While a burst is outstanding, acc_ready is low.
- R10: After reset, pf_valid is low, acc_ready is high and all entries are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Demand access present |
| acc_ready | output | 1 | Block can take an access (no burst pending) |
| acc_addr | input | ADDR_W | Demand byte address |
| acc_ctx | input | CTX_W | Requesting context, 0 = ignore |
| pf_valid | output | 1 | Prefetch address present |
| pf_ready | input | 1 | Consumer takes the prefetch address |
| pf_addr | output | ADDR_W | Block-aligned prefetch byte address |

## Verification
The assertions assume that tracked streams stay far enough from address zero and from the top of the block-number range that window ends and prefetch targets never wrap. The one-block step check relies on that. The checks also assume that a consumer holding pf_ready low eventually raises it. The stimulus places every stream thousands of blocks from either limit and keeps back-pressure to a few cycles. The block's own acc_ready rule guarantees that no new burst can start before the previous one has drained.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {ST_FREE = 2'd0, ST_TRAIN = 2'd1, ST_WATCH = 2'd2} st_e;
  typedef enum logic [1:0] {DIR_NONE = 2'd0, DIR_UP = 2'd1, DIR_DN = 2'd2} dir_e;
endpackage

// File: rtl/sp_entry_eval.sv
// Next-state evaluation of one table entry against the current block number.
module sp_entry_eval
  import sp_pkg::*;
#(
  parameter int BA_W     = 26,
  parameter int DEGREE   = 4,
  parameter int DISTANCE = 5
) (
  input  st_e             st_i,
  input  logic [BA_W-1:0] blk_i,
  input  logic [BA_W-1:0] alloc_i,
  input  logic [BA_W-1:0] start_i,
  input  logic [BA_W-1:0] stop_i,
  input  dir_e            vote0_i,
  input  dir_e            vote1_i,
  input  dir_e            tdir_i,
  output logic            match_o,
  output logic            issue_o,
  output st_e             st_o,
  output logic [BA_W-1:0] start_o,
  output logic [BA_W-1:0] stop_o,
  output dir_e            vote0_o,
  output dir_e            vote1_o,
  output dir_e            tdir_o
);
  localparam logic [BA_W-1:0] STEP = BA_W'(DEGREE);
  localparam logic [BA_W-1:0] NEAR = BA_W'(DISTANCE / 2);
  localparam logic [BA_W-1:0] SPAN = BA_W'(DISTANCE);

  logic [BA_W-1:0] gap, nstop_up, nstop_dn;
  logic            mon_hit, near;
  dir_e            vote;

  always_comb begin
    gap      = (blk_i >= alloc_i) ? (blk_i - alloc_i) : (alloc_i - blk_i);
    vote     = (blk_i > alloc_i) ? DIR_UP : DIR_DN;
    nstop_up = stop_i + STEP;
    nstop_dn = stop_i - STEP;
    mon_hit  = (st_i == ST_WATCH) &&
               (((tdir_i == DIR_UP) && (start_i < blk_i) && (blk_i < stop_i)) ||
                ((tdir_i == DIR_DN) && (start_i > blk_i) && (blk_i > stop_i)));
    near     = (st_i == ST_TRAIN) && (gap <= NEAR);

    st_o    = st_i;
    start_o = start_i;
    stop_o  = stop_i;
    vote0_o = vote0_i;
    vote1_o = vote1_i;
    tdir_o  = tdir_i;
    issue_o = 1'b0;

    if (mon_hit) begin
      issue_o = 1'b1;
      if (tdir_i == DIR_UP) begin
        stop_o = nstop_up;
        if (nstop_up - start_i > SPAN) start_o = start_i + STEP;
      end else begin
        stop_o = nstop_dn;
        if (start_i - nstop_dn > SPAN) start_o = start_i - STEP;
      end
    end else if (near) begin
      if (vote0_i == DIR_NONE) begin
        vote0_o = vote;
      end else if (vote == vote0_i) begin
        vote1_o = vote;
        tdir_o  = vote;
        start_o = alloc_i;
        stop_o  = (vote == DIR_UP) ? (blk_i + STEP) : (blk_i - STEP);
        st_o    = ST_WATCH;
      end else begin
        st_o    = ST_FREE;
        vote0_o = DIR_NONE;
        vote1_o = DIR_NONE;
        tdir_o  = DIR_NONE;
      end
    end
    match_o = mon_hit || near;
  end
endmodule

// File: rtl/sp_victim_pick.sv
// Chooses the slot for a new stream: first free entry, else the oldest rank.
module sp_victim_pick
  import sp_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  st_e              st_i   [ENTRIES],
  input  logic [IDX_W-1:0] rank_i [ENTRIES],
  output logic [IDX_W-1:0] vic_o
);
  logic found;

  always_comb begin
    found = 1'b0;
    vic_o = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (!found && st_i[e] == ST_FREE) begin
        vic_o = IDX_W'(e);
        found = 1'b1;
      end
    end
    if (!found) begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (rank_i[e] == IDX_W'(ENTRIES - 1)) vic_o = IDX_W'(e);
      end
    end
  end
endmodule

// File: rtl/sp_burst.sv
// Drains DEGREE consecutive block addresses through a valid/ready port.
module sp_burst #(
  parameter int ADDR_W = 32,
  parameter int OFS_W  = 6,
  parameter int DEGREE = 4,
  localparam int BA_W  = ADDR_W - OFS_W,
  localparam int CNT_W = $clog2(DEGREE + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [BA_W-1:0]   base_i,
  input  logic              up_i,
  input  logic              pf_ready_i,
  output logic              pf_valid_o,
  output logic [ADDR_W-1:0] pf_addr_o
);
  logic [BA_W-1:0]  cur_blk;
  logic [CNT_W-1:0] left;
  logic             up_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pf_valid_o <= 1'b0;
      cur_blk    <= '0;
      left       <= '0;
      up_q       <= 1'b0;
    end else if (start_i) begin
      pf_valid_o <= 1'b1;
      cur_blk    <= up_i ? base_i + 1'b1 : base_i - 1'b1;
      left       <= CNT_W'(DEGREE);
      up_q       <= up_i;
    end else if (pf_valid_o && pf_ready_i) begin
      if (left == CNT_W'(1)) begin
        pf_valid_o <= 1'b0;
      end else begin
        cur_blk <= up_q ? cur_blk + 1'b1 : cur_blk - 1'b1;
      end
      left <= left - 1'b1;
    end
  end

  assign pf_addr_o = {cur_blk, {OFS_W{1'b0}}};
endmodule

// File: rtl/stream_prefetch.sv
module stream_prefetch
  import sp_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BLK_BYTES = 64,
  parameter int CTX_W     = 2,
  parameter int ENTRIES   = 8,
  parameter int DEGREE    = 4,
  parameter int DISTANCE  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  output logic              acc_ready,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [CTX_W-1:0]  acc_ctx,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr
);
  localparam int OFS_W = $clog2(BLK_BYTES);
  localparam int BA_W  = ADDR_W - OFS_W;
  localparam int NCTX  = 1 << CTX_W;
  localparam int IDX_W = $clog2(ENTRIES);

  st_e              t_st    [NCTX][ENTRIES];
  logic [BA_W-1:0]  t_alloc [NCTX][ENTRIES];
  logic [BA_W-1:0]  t_start [NCTX][ENTRIES];
  logic [BA_W-1:0]  t_stop  [NCTX][ENTRIES];
  dir_e             t_v0    [NCTX][ENTRIES];
  dir_e             t_v1    [NCTX][ENTRIES];
  dir_e             t_dir   [NCTX][ENTRIES];
  logic [IDX_W-1:0] t_rank  [NCTX][ENTRIES];

  st_e              c_st    [ENTRIES];
  logic [BA_W-1:0]  c_alloc [ENTRIES];
  logic [BA_W-1:0]  c_start [ENTRIES];
  logic [BA_W-1:0]  c_stop  [ENTRIES];
  dir_e             c_v0    [ENTRIES];
  dir_e             c_v1    [ENTRIES];
  dir_e             c_dir   [ENTRIES];
  logic [IDX_W-1:0] c_rank  [ENTRIES];

  st_e              n_st    [ENTRIES];
  logic [BA_W-1:0]  n_start [ENTRIES];
  logic [BA_W-1:0]  n_stop  [ENTRIES];
  dir_e             n_v0    [ENTRIES];
  dir_e             n_v1    [ENTRIES];
  dir_e             n_dir   [ENTRIES];
  logic [ENTRIES-1:0] hit_v, iss_v;

  logic [BA_W-1:0]  blk;
  logic             take, hit_any, launch;
  logic [IDX_W-1:0] hit_idx, vic, sel, old_rank;
  logic             unused_ofs;

  assign blk        = acc_addr[ADDR_W-1:OFS_W];
  assign unused_ofs = ^acc_addr[OFS_W-1:0];

  always_comb begin
    for (int e = 0; e < ENTRIES; e++) begin
      c_st[e]    = t_st[acc_ctx][e];
      c_alloc[e] = t_alloc[acc_ctx][e];
      c_start[e] = t_start[acc_ctx][e];
      c_stop[e]  = t_stop[acc_ctx][e];
      c_v0[e]    = t_v0[acc_ctx][e];
      c_v1[e]    = t_v1[acc_ctx][e];
      c_dir[e]   = t_dir[acc_ctx][e];
      c_rank[e]  = t_rank[acc_ctx][e];
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_eval
    sp_entry_eval #(.BA_W(BA_W), .DEGREE(DEGREE), .DISTANCE(DISTANCE)) i_eval (
      .st_i(c_st[g]), .blk_i(blk), .alloc_i(c_alloc[g]), .start_i(c_start[g]),
      .stop_i(c_stop[g]), .vote0_i(c_v0[g]), .vote1_i(c_v1[g]), .tdir_i(c_dir[g]),
      .match_o(hit_v[g]), .issue_o(iss_v[g]), .st_o(n_st[g]), .start_o(n_start[g]),
      .stop_o(n_stop[g]), .vote0_o(n_v0[g]), .vote1_o(n_v1[g]), .tdir_o(n_dir[g])
    );
  end

  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (!hit_any && hit_v[e]) begin
        hit_idx = IDX_W'(e);
        hit_any = 1'b1;
      end
    end
  end

  sp_victim_pick #(.ENTRIES(ENTRIES)) i_pick (.st_i(c_st), .rank_i(c_rank), .vic_o(vic));

  assign take     = acc_valid && acc_ready && (acc_ctx != '0);
  assign sel      = hit_any ? hit_idx : vic;
  assign old_rank = c_rank[sel];
  assign launch   = take && hit_any && iss_v[hit_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCTX; c++) begin
        for (int e = 0; e < ENTRIES; e++) begin
          t_st[c][e]    <= ST_FREE;
          t_alloc[c][e] <= '0;
          t_start[c][e] <= '0;
          t_stop[c][e]  <= '0;
          t_v0[c][e]    <= DIR_NONE;
          t_v1[c][e]    <= DIR_NONE;
          t_dir[c][e]   <= DIR_NONE;
          t_rank[c][e]  <= IDX_W'(e);
        end
      end
    end else if (take) begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (IDX_W'(e) == sel) t_rank[acc_ctx][e] <= '0;
        else if (c_rank[e] < old_rank) t_rank[acc_ctx][e] <= c_rank[e] + 1'b1;
      end
      if (hit_any) begin
        t_st[acc_ctx][sel]    <= n_st[sel];
        t_start[acc_ctx][sel] <= n_start[sel];
        t_stop[acc_ctx][sel]  <= n_stop[sel];
        t_v0[acc_ctx][sel]    <= n_v0[sel];
        t_v1[acc_ctx][sel]    <= n_v1[sel];
        t_dir[acc_ctx][sel]   <= n_dir[sel];
      end else begin
        t_st[acc_ctx][sel]    <= ST_TRAIN;
        t_alloc[acc_ctx][sel] <= blk;
        t_start[acc_ctx][sel] <= '0;
        t_stop[acc_ctx][sel]  <= '0;
        t_v0[acc_ctx][sel]    <= DIR_NONE;
        t_v1[acc_ctx][sel]    <= DIR_NONE;
        t_dir[acc_ctx][sel]   <= DIR_NONE;
      end
    end
  end

  sp_burst #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .DEGREE(DEGREE)) i_burst (
    .clk(clk), .rst(rst), .start_i(launch), .base_i(c_stop[hit_idx]),
    .up_i(c_dir[hit_idx] == DIR_UP), .pf_ready_i(pf_ready),
    .pf_valid_o(pf_valid), .pf_addr_o(pf_addr)
  );

  assign acc_ready = !pf_valid;
endmodule

// File: rtl/sp_checker.sv
module sp_checker #(
  parameter int ADDR_W    = 32,
  parameter int BLK_BYTES = 64,
  parameter int CTX_W     = 2,
  parameter int DEGREE    = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic              acc_ready,
  input logic [CTX_W-1:0]  acc_ctx,
  input logic              pf_valid,
  input logic              pf_ready,
  input logic [ADDR_W-1:0] pf_addr
);
  localparam int OFS_W = $clog2(BLK_BYTES);
  localparam int CNT_W = $clog2(DEGREE + 1) + 1;

  logic [CNT_W-1:0] taken;

  always_ff @(posedge clk) begin
    if (rst || !pf_valid) taken <= '0;
    else if (pf_ready) taken <= taken + 1'b1;
  end

  // R9
  busy_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    pf_valid |-> !acc_ready);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr)));

  // R1
  align_chk: assert property (@(posedge clk) disable iff (rst)
    pf_valid |-> (pf_addr[OFS_W-1:0] == '0));

  // R2
  ctx0_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_ready && acc_ctx == '0) |=> !pf_valid);

  // R5
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (pf_valid && pf_ready) |=> (!pf_valid ||
      (pf_addr - $past(pf_addr) == ADDR_W'(BLK_BYTES)) ||
      ($past(pf_addr) - pf_addr == ADDR_W'(BLK_BYTES))));

  // R5
  burst_len_chk: assert property (@(posedge clk) disable iff (rst)
    pf_valid |-> (taken < CNT_W'(DEGREE)));
endmodule

bind stream_prefetch sp_checker #(
  .ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES), .CTX_W(CTX_W), .DEGREE(DEGREE)
) i_sp_checker (
  .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_ready(acc_ready),
  .acc_ctx(acc_ctx), .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr)
);

// File: tb/test_stream_prefetch.sv
`timescale 1ns/1ps
module test_stream_prefetch;
  localparam int DEG = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0;
  logic        acc_ready;
  logic [31:0] acc_addr = '0;
  logic [1:0]  acc_ctx = '0;
  logic        pf_valid;
  logic        pf_ready = 1'b1;
  logic [31:0] pf_addr;

  int          n_run = 0;
  int          n_fail = 0;
  logic [25:0] got [0:7];
  int          got_n;

  always #5 clk = ~clk;

  stream_prefetch #(.DISTANCE(12)) i_stream_prefetch (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_addr(acc_addr), .acc_ctx(acc_ctx), .pf_valid(pf_valid),
    .pf_ready(pf_ready), .pf_addr(pf_addr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // Offers one access, then records every prefetch seen over eight cycles.
  task automatic acc(input logic [1:0] ctx, input logic [25:0] b, input logic [5:0] ofs);
    while (!acc_ready) @(negedge clk);
    acc_valid = 1'b1;
    acc_addr  = {b, ofs};
    acc_ctx   = ctx;
    @(negedge clk);
    acc_valid = 1'b0;
    got_n = 0;
    for (int k = 0; k < 8; k++) begin
      if (pf_valid) begin
        chk(pf_addr[5:0] == 6'd0, "R1", "prefetch offset", pf_addr[5:0], 0);
        if (got_n < 8) got[got_n] = pf_addr[31:6];
        got_n++;
      end
      @(negedge clk);
    end
  endtask

  task automatic expect_none(input string req);
    chk(got_n == 0, req, "prefetch count", got_n, 0);
  endtask

  task automatic expect_burst(input string req, input logic [25:0] first, input bit up);
    chk(got_n == DEG, req, "prefetch count", got_n, DEG);
    for (int k = 0; k < DEG && k < got_n; k++) begin
      logic [25:0] e;
      e = up ? first + 26'(k) : first - 26'(k);
      chk(got[k] == e, req, "prefetch block", got[k], e);
    end
  endtask

  task automatic t_reset();
    do_reset();
    chk(pf_valid == 1'b0, "R10", "pf_valid after reset", pf_valid, 0);
    chk(acc_ready == 1'b1, "R10", "acc_ready after reset", acc_ready, 1);
  endtask

  localparam logic [25:0] A = 26'd1000;

  task automatic t_ascend();
    acc(2'd1, A, 6'd9);        expect_none("R3");
    acc(2'd1, A + 1, 6'd0);    expect_none("R3");
    acc(2'd1, A + 2, 6'd33);   expect_none("R3");
    acc(2'd1, A + 3, 6'd5);    expect_burst("R5", A + 7, 1'b1);
    acc(2'd1, A + 1, 6'd63);   expect_burst("R6", A + 11, 1'b1);
    acc(2'd1, A + 4, 6'd0);    expect_none("R6");
    acc(2'd1, A + 5, 6'd2);    expect_burst("R6", A + 15, 1'b1);
  endtask

  task automatic t_descend();
    logic [25:0] d;
    d = 26'd5000;
    acc(2'd2, d, 6'd1);        expect_none("R3");
    acc(2'd2, d - 1, 6'd0);    expect_none("R3");
    acc(2'd2, d - 2, 6'd7);    expect_none("R3");
    acc(2'd2, d - 3, 6'd0);    expect_burst("R5", d - 7, 1'b0);
    acc(2'd2, d, 6'd0);        expect_none("R5");
    acc(2'd2, d - 9, 6'd4);    expect_burst("R5", d - 11, 1'b0);
  endtask

  task automatic t_far();
    logic [25:0] f;
    f = 26'd20000;
    acc(2'd3, f, 6'd0);        expect_none("R3");
    acc(2'd3, f + 7, 6'd0);    expect_none("R3");
    acc(2'd3, f + 1, 6'd0);    expect_none("R3");
    acc(2'd3, f + 2, 6'd0);    expect_none("R3");
    acc(2'd3, f + 3, 6'd0);    expect_burst("R3", f + 7, 1'b1);
  endtask

  task automatic t_disagree();
    logic [25:0] g;
    g = 26'd40000;
    acc(2'd3, g, 6'd0);        expect_none("R4");
    acc(2'd3, g + 1, 6'd0);    expect_none("R4");
    acc(2'd3, g - 1, 6'd0);    expect_none("R4");
    acc(2'd3, g + 1, 6'd0);    expect_none("R4");
    acc(2'd3, g + 2, 6'd0);    expect_none("R4");
    acc(2'd3, g + 3, 6'd0);    expect_none("R4");
    acc(2'd3, g + 2, 6'd0);    expect_burst("R4", g + 8, 1'b1);
  endtask

  task automatic t_ctx0();
    logic [25:0] h;
    h = 26'd70000;
    for (int k = 0; k < 4; k++) begin
      acc(2'd0, h + 26'(k), 6'd0);
      expect_none("R2");
    end
  endtask

  task automatic t_ctx_sep();
    acc(2'd2, A + 10, 6'd0);   expect_none("R8");
    acc(2'd1, A + 10, 6'd0);   expect_burst("R8", A + 19, 1'b1);
  endtask

  task automatic t_backpressure();
    pf_ready = 1'b0;
    acc_valid = 1'b1;
    acc_addr  = {A + 26'd13, 6'd0};
    acc_ctx   = 2'd1;
    @(negedge clk);
    acc_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk(pf_valid == 1'b1, "R9", "valid held", pf_valid, 1);
      chk(pf_addr[31:6] == A + 23, "R9", "address held", pf_addr[31:6], A + 23);
      chk(acc_ready == 1'b0, "R9", "acc_ready during burst", acc_ready, 0);
      @(negedge clk);
    end
    pf_ready = 1'b1;
    got_n = 0;
    for (int k = 0; k < 8; k++) begin
      if (pf_valid) begin
        if (got_n < 8) got[got_n] = pf_addr[31:6];
        got_n++;
      end
      @(negedge clk);
    end
    expect_burst("R9", A + 23, 1'b1);
    chk(acc_ready == 1'b1, "R9", "acc_ready after burst", acc_ready, 1);
  endtask

  task automatic t_lru();
    logic [25:0] s;
    s = 26'd60000;
    do_reset();
    for (int k = 0; k < 8; k++) begin
      acc(2'd1, s + 26'(100 * k), 6'd0);
      expect_none("R7");
    end
    acc(2'd1, s + 1, 6'd0);    expect_none("R7");
    acc(2'd1, s + 2, 6'd0);    expect_none("R7");
    acc(2'd1, 26'd90000, 6'd0); expect_none("R7");
    acc(2'd1, s + 101, 6'd0);  expect_none("R7");
    acc(2'd1, s + 102, 6'd0);  expect_none("R7");
    acc(2'd1, s + 103, 6'd0);  expect_none("R7");
    acc(2'd1, s + 3, 6'd0);    expect_burst("R7", s + 7, 1'b1);
    acc(2'd1, s + 104, 6'd0);  expect_burst("R7", s + 108, 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_ascend();
    t_descend();
    t_far();
    t_disagree();
    t_ctx0();
    t_ctx_sep();
    t_backpressure();
    t_lru();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule